// File: doc/BRIEF.md
# Bit-Clock to Frame-Sync Ratio Detector

This block runs on a bit clock that is synchronous to an 8 kHz frame strobe. It counts the bit-clock cycles in each frame period, decides which supported bit-clock rate is present, and hands a 3-bit multiplier code to a downstream clock synthesizer. The synthesizer aims at 28.672 MHz. The supported rates run from 256 kHz to 8.192 MHz. The 1.536 MHz and 1.544 MHz rates share one code, so nine rates fit into eight codes.

Measurement begins when the active-low reset is released, which should happen only once the clock and the frame strobe are stable. The first frame after release is treated as partial. The code is captured only after two complete frames in a row give the same count. The code then stays fixed until the next reset. A settle flag follows 64 bit-clock cycles after capture, so that downstream logic knows when the synthesizer may be used. Unsupported ratios, missing strobes and later changes of rate show up on an error flag.

Top module: `clk_ratio_detect`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state is `mult_code` = 0, `code_valid` = 0, `ratio_err` = 0 and `settle_done` = 0. Reset is synchronous.
- R2: A frame count is the number of rising clock edges from one sampled rising edge of `fsync` to the next. The first rising edge after reset only starts counting and yields no count.
- R3: Counts are mapped to `mult_code` as follows: 32→0, 64→1, 96→2, 128→3, 192→4, 256→5, 512→6, 1024→7.
- R4: A count of 193 is mapped to code 4, the same code as 192.
- R5: `code_valid` rises at the clock edge that samples the second of two consecutive, identical, supported counts. `mult_code` takes its value at that same edge. A single good count does not raise `code_valid`.
- R6: Before capture, a count that is not in the table raises `ratio_err` and resets the two-frame match. The next supported count clears `ratio_err`. Capture still requires two matching counts.
- R7: If more than 1100 cycles pass after the last counted `fsync` rising edge without a new one, `ratio_err` rises even though no new edge arrives.
- R8: `settle_done` rises exactly 64 clock edges after the edge at which `code_valid` rose, and stays high until reset.
- R9: After capture, `mult_code` and `code_valid` do not change until reset. A later count that is unsupported, or whose code differs from the captured code, sets `ratio_err`, and `ratio_err` then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fsync | input | 1 | 8 kHz frame strobe, synchronous to `clk` |
| mult_code | output | 3 | Captured multiplier code for the synthesizer |
| code_valid | output | 1 | High once the code has been captured |
| ratio_err | output | 1 | Unsupported, missing or changed frame ratio |
| settle_done | output | 1 | Settle interval after capture has elapsed |

## Verification
Two things can happen on the same edge: the end of the 64-cycle settle interval and the first post-capture frame edge whose count disagrees with the captured code. The bench captures code 0 from 32-cycle frames. It then holds the strobe low so that the next rising edge lands exactly 64 cycles after capture, which gives a count of 64 (code 1). The bench checks the cycle just before that edge, where both flags must still be low, and the cycle just after it, where `settle_done` and `ratio_err` must both be high while `mult_code` stays at 0.

// File: rtl/rd_pkg.sv
package rd_pkg;

    localparam int unsigned CODE_W        = 3;
    localparam int unsigned NUM_CODES     = 1 << CODE_W;
    localparam int unsigned BASE_RATIO    = 32;
    localparam int unsigned ALT_RATIO     = 193;
    localparam int unsigned MAX_COUNT_DEF = 1100;
    localparam int unsigned SETTLE_DEF    = 64;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t ALT_CODE = code_t'(4);

    typedef struct packed {
        logic  ok;
        code_t code;
    } class_t;

    typedef enum logic [1:0] {
        ST_SEEK   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_LOCKED = 2'd2
    } lock_st_t;

    function automatic int unsigned nominal_ratio(input int unsigned idx);
        int unsigned mul;
        case (idx)
            0:       mul = 1;
            1:       mul = 2;
            2:       mul = 3;
            3:       mul = 4;
            4:       mul = 6;
            5:       mul = 8;
            6:       mul = 16;
            default: mul = 32;
        endcase
        return mul * BASE_RATIO;
    endfunction

    function automatic class_t classify(input int unsigned cnt);
        class_t r;
        r.ok   = 1'b0;
        r.code = '0;
        for (int unsigned i = 0; i < NUM_CODES; i++) begin
            if (cnt == nominal_ratio(i)) begin
                r.ok   = 1'b1;
                r.code = code_t'(i);
            end
        end
        if (cnt == ALT_RATIO) begin
            r.ok   = 1'b1;
            r.code = ALT_CODE;
        end
        return r;
    endfunction

endpackage

// File: rtl/rd_edge_count.sv
module rd_edge_count #(
    parameter int unsigned MAX_COUNT = 1100,
    parameter int unsigned CNT_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic             meas_fire,
    output logic             meas_ovf,
    output logic [CNT_W-1:0] meas_count
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(MAX_COUNT);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(MAX_COUNT + 1);

    logic             fs_q;
    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic             rise;

    assign rise       = fsync & ~fs_q;
    assign meas_fire  = rise & armed;
    assign meas_ovf   = armed & ~rise & (cnt == LIM);
    assign meas_count = (cnt == SAT) ? SAT : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q  <= 1'b0;
            armed <= 1'b0;
            cnt   <= '0;
        end else begin
            fs_q <= fsync;
            if (rise) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (armed && cnt != SAT) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_OVF_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        meas_ovf |=> !meas_ovf); // R7

    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        meas_fire |-> meas_count != '0); // R2

    AST_NO_FIRE_BEFORE_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !fsync) |=> !meas_fire); // R2

endmodule

// File: rtl/rd_classify.sv
module rd_classify #(
    parameter int unsigned CNT_W = 11
) (
    input  logic [CNT_W-1:0] count,
    output rd_pkg::class_t   cls
);
    logic [31:0] count_ext;

    assign count_ext = {{(32-CNT_W){1'b0}}, count};
    assign cls       = rd_pkg::classify(count_ext);

endmodule

// File: rtl/rd_lock.sv
module rd_lock #(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_fire,
    input  logic             meas_ovf,
    input  logic [CNT_W-1:0] meas_count,
    input  rd_pkg::class_t   cls,
    output rd_pkg::code_t    code,
    output logic             valid,
    output logic             err
);
    import rd_pkg::*;

    lock_st_t         st;
    logic [CNT_W-1:0] prev_cnt;
    code_t            code_q;
    logic             err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_SEEK;
            prev_cnt <= '0;
            code_q   <= '0;
            err_q    <= 1'b0;
        end else begin
            case (st)
                ST_LOCKED: begin
                    if (meas_ovf || (meas_fire && (!cls.ok || cls.code != code_q)))
                        err_q <= 1'b1;
                end
                default: begin
                    if (meas_ovf) begin
                        err_q <= 1'b1;
                        st    <= ST_SEEK;
                    end else if (meas_fire) begin
                        if (!cls.ok) begin
                            err_q <= 1'b1;
                            st    <= ST_SEEK;
                        end else begin
                            err_q <= 1'b0;
                            if (st == ST_HOLD && meas_count == prev_cnt) begin
                                st     <= ST_LOCKED;
                                code_q <= cls.code;
                            end else begin
                                st       <= ST_HOLD;
                                prev_cnt <= meas_count;
                            end
                        end
                    end
                end
            endcase
        end
    end

    assign code  = code_q;
    assign valid = (st == ST_LOCKED);
    assign err   = err_q;

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> valid); // R9

    AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> $stable(code)); // R9

    AST_ERR_STICKY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && err) |=> err); // R9

    AST_LOCK_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !meas_fire) |=> !valid); // R5

    AST_LOCK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && meas_fire && cls.ok) |=> !err); // R6

endmodule

// File: rtl/rd_settle.sv
module rd_settle #(
    parameter int unsigned SETTLE_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    output logic done
);
    localparam int unsigned SW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [SW-1:0] LAST = SW'(SETTLE_CYCLES - 1);

    logic [SW-1:0] cnt;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            done_q <= 1'b0;
        end else if (valid && !done_q) begin
            if (cnt == LAST)
                done_q <= 1'b1;
            else
                cnt <= cnt + 1'b1;
        end
    end

    assign done = done_q;

    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> valid); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R8

    AST_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> !done); // R8

endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect #(
    parameter int unsigned MAX_COUNT     = rd_pkg::MAX_COUNT_DEF,
    parameter int unsigned SETTLE_CYCLES = rd_pkg::SETTLE_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fsync,
    output logic [2:0] mult_code,
    output logic       code_valid,
    output logic       ratio_err,
    output logic       settle_done
);
    localparam int unsigned CNT_W = $clog2(MAX_COUNT + 2);

    logic             meas_fire;
    logic             meas_ovf;
    logic [CNT_W-1:0] meas_count;
    rd_pkg::class_t   cls;
    rd_pkg::code_t    code;
    logic             valid;

    rd_edge_count #(.MAX_COUNT(MAX_COUNT), .CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .meas_fire  (meas_fire),
        .meas_ovf   (meas_ovf),
        .meas_count (meas_count)
    );

    rd_classify #(.CNT_W(CNT_W)) u_class (
        .count (meas_count),
        .cls   (cls)
    );

    rd_lock #(.CNT_W(CNT_W)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_fire  (meas_fire),
        .meas_ovf   (meas_ovf),
        .meas_count (meas_count),
        .cls        (cls),
        .code       (code),
        .valid      (valid),
        .err        (ratio_err)
    );

    rd_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (valid),
        .done  (settle_done)
    );

    assign mult_code  = code;
    assign code_valid = valid;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!code_valid && !ratio_err && !settle_done && mult_code == 3'd0)); // R1

endmodule

// File: tb/clk_ratio_detect_bench.sv
`timescale 1ns/1ps
module clk_ratio_detect_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic [2:0] mult_code;
    logic       code_valid;
    logic       ratio_err;
    logic       settle_done;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    clk_ratio_detect u_clk_ratio_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .fsync       (fsync),
        .mult_code   (mult_code),
        .code_valid  (code_valid),
        .ratio_err   (ratio_err),
        .settle_done (settle_done)
    );

    typedef struct packed {
        int       per;
        logic [2:0] code;
        logic     valid;
        logic     err;
    } vec_t;

    localparam int VEC_N = 13;
    localparam vec_t VECS [VEC_N] = '{
        '{32,   3'd0, 1'b1, 1'b0},   // R3
        '{64,   3'd1, 1'b1, 1'b0},   // R3
        '{96,   3'd2, 1'b1, 1'b0},   // R3
        '{128,  3'd3, 1'b1, 1'b0},   // R3
        '{192,  3'd4, 1'b1, 1'b0},   // R3
        '{193,  3'd4, 1'b1, 1'b0},   // R4
        '{256,  3'd5, 1'b1, 1'b0},   // R3
        '{512,  3'd6, 1'b1, 1'b0},   // R3
        '{1024, 3'd7, 1'b1, 1'b0},   // R3
        '{100,  3'd0, 1'b0, 1'b1},   // R6
        '{33,   3'd0, 1'b0, 1'b1},   // R6
        '{1050, 3'd0, 1'b0, 1'b1},   // R6
        '{1150, 3'd0, 1'b0, 1'b1}    // R7
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic fs);
        fsync = fs;
        @(negedge clk);
    endtask

    task automatic frame(input int per);
        for (int c = 0; c < per; c++) step(c < per / 2);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fsync = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", code_valid, 0);
        chk("R1", "err in reset",   ratio_err, 0);
        chk("R1", "done in reset",  settle_done, 0);
        chk("R1", "code in reset",  mult_code, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);

        // Table walk: three frames per rate (arm, first count, matching count)
        for (int v = 0; v < VEC_N; v++) begin
            do_reset();
            frame(VECS[v].per);
            frame(VECS[v].per);
            chk("R5", $sformatf("valid after one count per=%0d", VECS[v].per), code_valid, 0);
            frame(VECS[v].per);
            chk("R3", $sformatf("valid per=%0d", VECS[v].per), code_valid, VECS[v].valid);
            chk("R6", $sformatf("err per=%0d", VECS[v].per), ratio_err, VECS[v].err);
            if (VECS[v].valid)
                chk("R3", $sformatf("code per=%0d", VECS[v].per), mult_code, VECS[v].code);
        end

        // R2 / R5: lock timing on the exact edge of the second matching count
        do_reset();
        step(1'b0);
        frame(64);
        frame(64);
        step(1'b1);
        chk("R5", "valid on second matching edge", code_valid, 1);
        chk("R2", "code from 64-cycle frames", mult_code, 1);

        // R6: bad counts then recovery
        do_reset();
        frame(100);
        frame(100);
        frame(100);
        chk("R6", "err after bad counts", ratio_err, 1);
        frame(64);
        frame(64);
        chk("R6", "err cleared by good count", ratio_err, 0);
        chk("R6", "no lock after one good count", code_valid, 0);
        frame(64);
        chk("R6", "lock after recovery", code_valid, 1);
        chk("R6", "code after recovery", mult_code, 1);

        // R5: unequal supported counts do not lock
        do_reset();
        frame(64);
        frame(128);
        frame(64);
        chk("R5", "no lock on unequal counts", code_valid, 0);

        // R7: strobe stops after arming
        do_reset();
        step(1'b1);
        for (int c = 0; c < 1099; c++) step(1'b0);
        chk("R7", "err before limit", ratio_err, 0);
        for (int c = 0; c < 10; c++) step(1'b0);
        chk("R7", "err after limit", ratio_err, 1);
        chk("R7", "no valid on timeout", code_valid, 0);

        // R9: rate change after lock
        do_reset();
        frame(128);
        frame(128);
        frame(128);
        chk("R9", "lock at 128", code_valid, 1);
        chk("R9", "err clear at lock", ratio_err, 0);
        frame(64);
        frame(64);
        frame(64);
        chk("R9", "code frozen", mult_code, 3);
        chk("R9", "valid kept", code_valid, 1);
        chk("R9", "sticky err", ratio_err, 1);
        frame(128);
        frame(128);
        chk("R9", "err stays after good frames", ratio_err, 1);

        // R8 + R9 on one edge: settle end and mismatching frame edge coincide
        do_reset();
        frame(32);
        frame(32);
        frame(32);
        chk("R8", "done low right after lock", settle_done, 0);
        for (int c = 0; c < 32; c++) step(1'b0);
        chk("R8", "done low at 63 cycles", settle_done, 0);
        chk("R9", "err low before mismatch edge", ratio_err, 0);
        step(1'b1);
        chk("R8", "done at 64 cycles", settle_done, 1);
        chk("R9", "err on mismatch edge", ratio_err, 1);
        chk("R9", "code kept on mismatch edge", mult_code, 0);
        for (int c = 0; c < 20; c++) step(1'b0);
        chk("R8", "done stays high", settle_done, 1);

        // R1: reset from a fully set state
        do_reset();
        step(1'b0);
        chk("R1", "valid after release", code_valid, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule